// File: doc/BRIEF.md
# Double-Buffered DMA Channel Sequencer

This block is the control sequencer of a single DMA channel that works with two buffer descriptors in turn. Software programs a base address and a transfer count for the buffer in use. While that buffer drains, software may program a second descriptor. When the active buffer finishes, the second descriptor takes its place without a gap. The sequencer follows the four channel states: idle, running, running with a next buffer queued, and stalled. It counts the bytes left in the active buffer and advances its address. It ends a buffer early when the peripheral signals end of transfer or an error.

Three flags tell software what to do next. The stall flag means the channel ran dry. The free-buffer flag means a queued descriptor has just been taken up, so the descriptor slot is open again. The error flag reports how the most recent buffer ended. Each flag drives an interrupt through its own mask bit. A read-only status word packs the flags, the state code and the occupancy of the packer, which is reported by the data path outside this block. The bus master and the data path are not part of this block. One transfer strobe per data item stands in for them.

Top module: `dma_chan_seq`

## Requirements
- R1: After synchronous reset the state code is idle (0), all three flags are 0, all interrupts are 0, bytes_rem is 0 and cur_addr is 0.
- R2: Enabling the channel from idle with no descriptor written enters the stalled state (code 1), and the stall flag and stall interrupt stay 0.
- R3: A descriptor written while idle and disabled is used on enable: the state becomes running (code 2), cur_addr equals the base and bytes_rem equals the count. Each transfer strobe while running lowers bytes_rem by one and raises cur_addr by one.
- R4: A descriptor write while running queues it and enters the queued state (code 3). The active address and count keep counting.
- R5: When the active buffer completes in the queued state, the queued descriptor becomes active, the state returns to running and the free-buffer flag becomes 1. The flag is 0 in every state other than running, and a further descriptor write clears it.
- R6: When the active buffer completes while running with nothing queued, the state becomes stalled and the stall flag becomes 1. bytes_rem then holds 0 if the count ran out, or the untransferred remainder if the peripheral ended the buffer.
- R7: A descriptor write while stalled makes the descriptor active, enters running and clears the stall flag.
- R8: A buffer that ends with the error input sets the error flag to 1. The flag keeps the outcome of the most recent completed buffer, so the next clean completion returns it to 0.
- R9: Each interrupt is its flag ANDed with a mask bit. Mask bit 0 gates stall, bit 1 gates free-buffer and bit 2 gates error.
- R10: Deasserting enable returns the channel to idle from any state within one cycle and clears all flags. It also discards any descriptor, so a later enable without a new write stalls.
- R11: The status word has the stall flag at bit 0, the free-buffer flag at bit 1 and the error flag at bit 2. The state code (idle 0, stalled 1, running 2, queued 3) sits at bits 4:3, and the packer occupancy sits at bits from 5 upward.
- R12: A descriptor write in the same cycle as completion while running becomes active at once, with no stall. A descriptor write in the same cycle as completion in the queued state is discarded.
- R13: The transfer strobe, end-of-transfer and error inputs have no effect in the idle and stalled states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable level |
| base_wr | input | 1 | Descriptor write strobe |
| wr_addr | input | AW | Base address of the written descriptor |
| wr_cnt | input | CW | Item count of the written descriptor |
| xfer | input | 1 | One data item moved |
| per_end | input | 1 | Peripheral end of transfer |
| per_err | input | 1 | Peripheral transfer error |
| pack_cnt | input | PW | Items held in packer/unpacker |
| irq_mask | input | 3 | Interrupt enables: bit0 stall, bit1 free-buffer, bit2 error |
| irq_stall | output | 1 | Stall interrupt |
| irq_nfb | output | 1 | Free-buffer interrupt |
| irq_err | output | 1 | Error interrupt |
| cur_addr | output | AW | Active buffer address |
| bytes_rem | output | CW | Items left in the active buffer |
| status | output | PW+5 | Read-only status word |

## Verification
The bench builds the channel with an 8-bit address, a 4-bit count and a 3-bit packer field. Every buffer length from 1 to 12 can then be run to exhaustion, and each intermediate count can be checked. All eight mask values and all eight packer values are swept against fixed flag patterns. The short count makes the two same-cycle collisions between a descriptor write and completion, and the early peripheral ending, cheap to set up exactly.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int FLAG_W = 3;
    localparam int ST_CODE_W = 2;

    typedef enum logic [ST_CODE_W-1:0] {
        CH_IDLE  = 2'd0,
        CH_STALL = 2'd1,
        CH_ON    = 2'd2,
        CH_NEXT  = 2'd3
    } ch_state_e;

    typedef struct packed {
        logic err;
        logic nfb;
        logic stall;
    } ch_flags_t;

    typedef struct packed {
        logic ld_cur;
        logic ld_nxt;
        logic promote;
    } buf_ctl_t;

    function automatic logic [FLAG_W-1:0] irq_gate(ch_flags_t f, logic [FLAG_W-1:0] m);
        return f & m;
    endfunction

endpackage

// File: rtl/dma_buf_regs.sv
module dma_buf_regs
    import dma_seq_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  buf_ctl_t      ctl,
    input  logic          count_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_cnt,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] bytes_rem,
    output logic          last
);

    logic [AW-1:0] cur_addr_q, nxt_addr_q;
    logic [CW-1:0] rem_q, nxt_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr_q <= '0;
            rem_q      <= '0;
            nxt_addr_q <= '0;
            nxt_cnt_q  <= '0;
        end else begin
            if (ctl.ld_cur) begin
                cur_addr_q <= wr_addr;
                rem_q      <= wr_cnt;
            end else if (ctl.promote) begin
                cur_addr_q <= nxt_addr_q;
                rem_q      <= nxt_cnt_q;
            end else if (count_en) begin
                cur_addr_q <= cur_addr_q + 1'b1;
                rem_q      <= (rem_q == '0) ? '0 : rem_q - 1'b1;
            end
            if (ctl.ld_nxt) begin
                nxt_addr_q <= wr_addr;
                nxt_cnt_q  <= wr_cnt;
            end
        end
    end

    assign cur_addr  = cur_addr_q;
    assign bytes_rem = rem_q;
    assign last      = (rem_q <= CW'(1));

    AST_REM_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        !(ctl.ld_cur || ctl.promote) |=> (rem_q <= $past(rem_q))); // R3

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      base_wr,
    input  logic      xfer,
    input  logic      per_end,
    input  logic      per_err,
    input  logic      last,
    output ch_state_e state,
    output ch_flags_t flags,
    output buf_ctl_t  ctl,
    output logic      count_en
);

    ch_state_e state_q, state_d;
    ch_flags_t flags_q, flags_d;
    logic      cur_valid_q, cur_valid_d;
    logic      run, done;

    assign run      = en && (state_q == CH_ON || state_q == CH_NEXT);
    assign done     = run && (per_end || per_err || (xfer && last));
    assign count_en = run && xfer;

    always_comb begin
        state_d = state_q;
        ctl     = '0;
        if (!en) begin
            state_d    = CH_IDLE;
            ctl.ld_cur = (state_q == CH_IDLE) && base_wr;
        end else begin
            unique case (state_q)
                CH_IDLE: begin
                    ctl.ld_cur = base_wr;
                    state_d    = (cur_valid_q || base_wr) ? CH_ON : CH_STALL;
                end
                CH_ON: begin
                    if (done) begin
                        if (base_wr) ctl.ld_cur = 1'b1;
                        else         state_d    = CH_STALL;
                    end else if (base_wr) begin
                        ctl.ld_nxt = 1'b1;
                        state_d    = CH_NEXT;
                    end
                end
                CH_NEXT: begin
                    if (done) begin
                        ctl.promote = 1'b1;
                        state_d     = CH_ON;
                    end else if (base_wr) begin
                        ctl.ld_nxt = 1'b1;
                    end
                end
                CH_STALL: begin
                    if (base_wr) begin
                        ctl.ld_cur = 1'b1;
                        state_d    = CH_ON;
                    end
                end
                default: state_d = CH_IDLE;
            endcase
        end
    end

    always_comb begin
        flags_d = '0;
        if (en) begin
            flags_d.stall = (state_d == CH_STALL) && (flags_q.stall || state_q == CH_ON);
            flags_d.nfb   = (state_q == CH_NEXT && done) ||
                            (state_q == CH_ON && state_d == CH_ON && !done && flags_q.nfb);
            flags_d.err   = done ? per_err : flags_q.err;
        end
        cur_valid_d = (state_q == CH_IDLE && !en) && (cur_valid_q || base_wr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= CH_IDLE;
            flags_q     <= '0;
            cur_valid_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            flags_q     <= flags_d;
            cur_valid_q <= cur_valid_d;
        end
    end

    assign state = state_q;
    assign flags = flags_q;

    AST_NFB_ONLY_ON: assert property (@(posedge clk) disable iff (rst)
        flags_q.nfb |-> (state_q == CH_ON)); // R5
    AST_PROMOTE_NFB: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_NEXT && done) |=> (flags_q.nfb && state_q == CH_ON)); // R5
    AST_STALL_IN_STALL: assert property (@(posedge clk) disable iff (rst)
        flags_q.stall |-> (state_q == CH_STALL)); // R6
    AST_NO_STALL_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_IDLE) |=> !flags_q.stall); // R2
    AST_STALL_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_STALL && en && base_wr) |=> (state_q == CH_ON && !flags_q.stall)); // R7
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state_q == CH_IDLE && flags_q == '0)); // R10

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 8,
    parameter int PW = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    input  logic                        base_wr,
    input  logic [AW-1:0]               wr_addr,
    input  logic [CW-1:0]               wr_cnt,
    input  logic                        xfer,
    input  logic                        per_end,
    input  logic                        per_err,
    input  logic [PW-1:0]               pack_cnt,
    input  logic [FLAG_W-1:0]           irq_mask,
    output logic                        irq_stall,
    output logic                        irq_nfb,
    output logic                        irq_err,
    output logic [AW-1:0]               cur_addr,
    output logic [CW-1:0]               bytes_rem,
    output logic [PW+FLAG_W+ST_CODE_W-1:0] status
);

    ch_state_e           state;
    ch_flags_t           flags;
    buf_ctl_t            ctl;
    logic                count_en;
    logic                last;
    logic [FLAG_W-1:0]   irq_vec;

    dma_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .base_wr  (base_wr),
        .xfer     (xfer),
        .per_end  (per_end),
        .per_err  (per_err),
        .last     (last),
        .state    (state),
        .flags    (flags),
        .ctl      (ctl),
        .count_en (count_en)
    );

    dma_buf_regs #(.AW(AW), .CW(CW)) u_bufs (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .count_en  (count_en),
        .wr_addr   (wr_addr),
        .wr_cnt    (wr_cnt),
        .cur_addr  (cur_addr),
        .bytes_rem (bytes_rem),
        .last      (last)
    );

    assign irq_vec   = irq_gate(flags, irq_mask);
    assign irq_stall = irq_vec[0];
    assign irq_nfb   = irq_vec[1];
    assign irq_err   = irq_vec[2];
    assign status    = {pack_cnt, state, flags};

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        (irq_stall |-> irq_mask[0]) and (irq_nfb |-> irq_mask[1]) and (irq_err |-> irq_mask[2])); // R9

endmodule

// File: tb/tb_dma_chan_seq.sv
`timescale 1ns/1ps
module tb_dma_chan_seq;

    localparam int AW = 8;
    localparam int CW = 4;
    localparam int PW = 3;
    localparam int S_IDLE = 0, S_STALL = 1, S_ON = 2, S_NEXT = 3;

    logic clk = 1'b0;
    logic rst, en, base_wr, xfer, per_end, per_err;
    logic [AW-1:0] wr_addr;
    logic [CW-1:0] wr_cnt;
    logic [PW-1:0] pack_cnt;
    logic [2:0]    irq_mask;
    logic irq_stall, irq_nfb, irq_err;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] bytes_rem;
    logic [PW+4:0] status;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dma_chan_seq #(.AW(AW), .CW(CW), .PW(PW)) dut (
        .clk(clk), .rst(rst), .en(en), .base_wr(base_wr), .wr_addr(wr_addr),
        .wr_cnt(wr_cnt), .xfer(xfer), .per_end(per_end), .per_err(per_err),
        .pack_cnt(pack_cnt), .irq_mask(irq_mask), .irq_stall(irq_stall),
        .irq_nfb(irq_nfb), .irq_err(irq_err), .cur_addr(cur_addr),
        .bytes_rem(bytes_rem), .status(status)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_base(input int a, input int c);
        base_wr = 1'b1; wr_addr = AW'(a); wr_cnt = CW'(c);
        cyc();
        base_wr = 1'b0;
    endtask

    function automatic int st_code(); return int'(status[4:3]); endfunction

    initial begin
        #2000000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; en = 0; base_wr = 0; xfer = 0; per_end = 0; per_err = 0;
        wr_addr = '0; wr_cnt = '0; pack_cnt = '0; irq_mask = 3'b111;
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R1 reset state
        chk("R1 status", int'(status), 0);
        chk("R1 irqs", int'({irq_err, irq_nfb, irq_stall}), 0);
        chk("R1 rem", int'(bytes_rem), 0);
        chk("R1 addr", int'(cur_addr), 0);

        // R2 enable without descriptor
        en = 1; cyc();
        chk("R2 state", st_code(), S_STALL);
        chk("R2 stall flag", int'(status[0]), 0);
        chk("R2 irq_stall", int'(irq_stall), 0);

        // R13 inputs ignored while stalled
        xfer = 1; per_end = 1; per_err = 1; cyc();
        xfer = 0; per_end = 0; per_err = 0;
        chk("R13 state", st_code(), S_STALL);
        chk("R13 err flag", int'(status[2]), 0);
        chk("R13 rem", int'(bytes_rem), 0);

        // R7 leave stall with descriptor write
        wr_base(8'h20, 5);
        chk("R7 state", st_code(), S_ON);
        chk("R7 stall", int'(status[0]), 0);
        chk("R3 rem load", int'(bytes_rem), 5);
        chk("R3 addr load", int'(cur_addr), 8'h20);

        // R3 R6 R10 sweep of buffer lengths
        for (int n = 1; n <= 12; n++) begin
            en = 0; cyc();
            chk("R10 idle", st_code(), S_IDLE);
            wr_base(8'h40 + n, n);
            chk("R3 idle hold", st_code(), S_IDLE);
            en = 1; cyc();
            chk("R3 on", st_code(), S_ON);
            chk("R3 rem start", int'(bytes_rem), n);
            for (int k = 1; k <= n; k++) begin
                xfer = 1; cyc();
                chk("R3 rem step", int'(bytes_rem), n - k);
                chk("R3 addr step", int'(cur_addr), (8'h40 + n + k) % 256);
                if (k < n) chk("R3 state step", st_code(), S_ON);
            end
            xfer = 0;
            chk("R6 stall state", st_code(), S_STALL);
            chk("R6 stall flag", int'(status[0]), 1);
            chk("R9 irq_stall", int'(irq_stall), 1);
            chk("R8 clean err", int'(status[2]), 0);
        end

        // R4 R5 ping-pong
        wr_base(8'h10, 3);
        wr_base(8'h80, 4);
        chk("R4 state", st_code(), S_NEXT);
        chk("R4 rem", int'(bytes_rem), 3);
        chk("R4 addr", int'(cur_addr), 8'h10);
        chk("R5 nfb in next", int'(status[1]), 0);
        xfer = 1; cyc(); cyc();
        chk("R4 counting", int'(bytes_rem), 1);
        chk("R4 still next", st_code(), S_NEXT);
        cyc(); xfer = 0;
        chk("R5 state", st_code(), S_ON);
        chk("R5 rem", int'(bytes_rem), 4);
        chk("R5 addr", int'(cur_addr), 8'h80);
        chk("R5 nfb", int'(status[1]), 1);
        chk("R5 irq_nfb", int'(irq_nfb), 1);
        irq_mask = 3'b101; #1;
        chk("R9 nfb masked", int'(irq_nfb), 0);
        irq_mask = 3'b111;
        wr_base(8'h90, 2);
        chk("R5 nfb cleared", int'(status[1]), 0);
        per_end = 1; cyc(); per_end = 0;
        chk("R5 promote by end", st_code(), S_ON);
        chk("R5 promote rem", int'(bytes_rem), 2);
        chk("R5 promote addr", int'(cur_addr), 8'h90);
        chk("R5 nfb again", int'(status[1]), 1);
        xfer = 1; cyc(); xfer = 0;
        per_end = 1; cyc(); per_end = 0;
        chk("R6 end state", st_code(), S_STALL);
        chk("R6 end remainder", int'(bytes_rem), 1);
        chk("R5 nfb off in stall", int'(status[1]), 0);

        // R8 error ending
        wr_base(8'h30, 6);
        xfer = 1; cyc(); xfer = 0;
        per_err = 1; cyc(); per_err = 0;
        chk("R8 state", st_code(), S_STALL);
        chk("R8 err flag", int'(status[2]), 1);
        chk("R8 irq_err", int'(irq_err), 1);
        chk("R8 rem", int'(bytes_rem), 5);
        for (int m = 0; m < 8; m++) begin
            irq_mask = 3'(m); #1;
            chk("R9 mask stall", int'(irq_stall), m & 1);
            chk("R9 mask nfb", int'(irq_nfb), 0);
            chk("R9 mask err", int'(irq_err), (m >> 2) & 1);
        end
        irq_mask = 3'b111;
        for (int p = 0; p < 8; p++) begin
            pack_cnt = 3'(p); #1;
            chk("R11 pack field", int'(status[7:5]), p);
            chk("R11 word", int'(status), (p << 5) | (S_STALL << 3) | 5);
        end
        pack_cnt = '0;
        wr_base(8'h50, 2);
        chk("R8 err held", int'(status[2]), 1);
        xfer = 1; cyc(); cyc(); xfer = 0;
        chk("R8 clean clears", int'(status[2]), 0);
        chk("R8 stalled", st_code(), S_STALL);

        // R12 collisions
        wr_base(8'h60, 2);
        xfer = 1; cyc();
        base_wr = 1; wr_addr = 8'h70; wr_cnt = 7; cyc();
        base_wr = 0; xfer = 0;
        chk("R12 on collide state", st_code(), S_ON);
        chk("R12 on collide rem", int'(bytes_rem), 7);
        chk("R12 on collide addr", int'(cur_addr), 8'h70);
        chk("R12 on collide stall", int'(status[0]), 0);
        wr_base(8'hA0, 3);
        base_wr = 1; wr_addr = 8'hB0; wr_cnt = 9; per_end = 1; cyc();
        base_wr = 0; per_end = 0;
        chk("R12 next collide state", st_code(), S_ON);
        chk("R12 next collide rem", int'(bytes_rem), 3);
        chk("R12 next collide addr", int'(cur_addr), 8'hA0);
        xfer = 1; repeat (3) cyc(); xfer = 0;
        chk("R12 write dropped", st_code(), S_STALL);

        // R10 disable from queued state
        wr_base(8'hC0, 4);
        wr_base(8'hD0, 4);
        chk("R10 pre next", st_code(), S_NEXT);
        en = 0; cyc();
        chk("R10 idle", st_code(), S_IDLE);
        chk("R10 flags", int'(status[2:0]), 0);
        xfer = 1; per_err = 1; cyc(); xfer = 0; per_err = 0;
        chk("R13 idle ignored", int'(status[2:0]), 0);
        chk("R13 idle rem", int'(bytes_rem), 4);
        en = 1; cyc();
        chk("R10 re-enable stalls", st_code(), S_STALL);
        chk("R10 no stall flag", int'(status[0]), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule